// File: doc/BRIEF.md
# Serial Boot Image Parser

This block turns a byte-serial boot image into memory writes. Bytes arrive over a valid/ready handshake. The image is a chain of blocks. Each block opens with an eight-byte header that gives a type flag, a 24-bit destination address and a word count. Depending on the flag, the header is followed by packed payload words or by nothing at all.

For each word, the parser raises a write request on a simple memory port. The request carries a 24-bit address, 24-bit data and a select bit that chooses program memory (24-bit words) or data memory (16-bit words). A block whose flag marks it as the last one ends the load. The block then raises `done` and presents the entry address where execution should begin.

The stream carries no integrity check, and the parser performs none. The only defect it reacts to is a flag value outside the defined set. Such a flag halts the parser and raises a sticky error.

Top module: `boot_stream_parser`

## Requirements
- R1: A header is eight bytes, each 16-bit field sent low byte first, in this order: flag (only its low byte is decoded, the high byte is ignored), address bits 15:0, address bits 23:16 followed by one pad byte, word count.
- R2: Flag low bits 0 = 0 selects program memory. Each payload word is three bytes (bits 7:0, 15:8, 23:16) and is written with `mem_pm` = 1.
- R3: Flag low bits 0 = 1 selects data memory. Each payload word is two bytes, low byte first, and is written with `mem_pm` = 0 and `mem_data[23:16]` = 0.
- R4: The first write of a block goes to the header address. Each following write goes to the previous address plus one, with carry across all 24 bits.
- R5: Flag bit 2 set (values 0x04 to 0x07) marks a zero-fill block. No payload bytes follow its header, and it produces word-count writes of data 0 to the memory chosen by bit 0.
- R6: Flag bit 1 set (0x02, 0x03, 0x06, 0x07) marks the final block. After its last write, `done` goes high and stays high, `start_addr` shows 0x000000, and `in_ready` stays low.
- R7: A header with word count 0 produces no write. The parser then expects the next header, unless the block is final, in which case `done` is raised.
- R8: A flag low byte in the range 0x08 to 0xFF raises `err`, which stays high. After that, no write occurs and `in_ready` stays low.
- R9: While `mem_wr` is high and `mem_ready` is low, `mem_wr`, `mem_addr`, `mem_data` and `mem_pm` hold, and `in_ready` is low, so no byte is lost.
- R10: After reset, `in_ready` = 1, `mem_wr` = 0, `done` = 0 and `err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Parser accepts a byte this cycle |
| mem_wr | output | 1 | Write request, held until `mem_ready` |
| mem_addr | output | 24 | Write address |
| mem_data | output | 24 | Write data (data-memory words zero-extended) |
| mem_pm | output | 1 | 1 = program memory, 0 = data memory |
| mem_ready | input | 1 | Memory accepts the pending write |
| done | output | 1 | Load complete |
| start_addr | output | 24 | Entry address, valid while `done` is high |
| err | output | 1 | Reserved flag seen, parser halted |

## Verification
Wrong internal state shows up at the ports at different speeds.

- A header byte index that slips by one misplaces the address or the count. This appears on the very first write of the next block, as a wrong `mem_addr` or a wrong number of writes.
- A wrong word-byte index corrupts `mem_data` on the first payload word.
- A remaining-count error appears only at the end of a block. It shows as missing or extra writes and as a `done` that comes early or never comes.

The stream used in the bench therefore mixes both memory types, a zero-fill block, an empty block and an address carry under random write stalls. It checks every write and the final state.

// File: rtl/boot_stream_parser.sv
module boot_stream_parser #(
  parameter logic [23:0] ENTRY_ADDR = 24'h000000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  output logic        mem_wr,
  output logic [23:0] mem_addr,
  output logic [23:0] mem_data,
  output logic        mem_pm,
  input  logic        mem_ready,
  output logic        done,
  output logic [23:0] start_addr,
  output logic        err
);

  typedef enum logic [2:0] {S_HDR, S_DATA, S_ZERO, S_DONE, S_ERR} state_t;

  state_t      st;
  logic [2:0]  hidx;
  logic [7:0]  flag_lo;
  logic [7:0]  cnt_lo;
  logic [23:0] addr;
  logic [15:0] rem;
  logic [1:0]  bidx;
  logic [23:0] word;
  logic        wpend;

  wire [15:0] hdr_cnt   = {in_data, cnt_lo};
  wire        acc       = in_valid & in_ready;
  wire        last_byte = flag_lo[0] ? (bidx == 2'd1) : (bidx == 2'd2);
  wire        wdone     = mem_wr & mem_ready;
  wire        blk_end   = wdone & (rem == 16'd1);
  wire        is_final  = flag_lo[1];

  assign in_ready   = (st == S_HDR) | ((st == S_DATA) & ~wpend);
  assign mem_wr     = (st == S_ZERO) | ((st == S_DATA) & wpend);
  assign mem_addr   = addr;
  assign mem_data   = word;
  assign mem_pm     = ~flag_lo[0];
  assign done       = (st == S_DONE);
  assign err        = (st == S_ERR);
  assign start_addr = done ? ENTRY_ADDR : 24'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_HDR;
      hidx    <= '0;
      flag_lo <= '0;
      cnt_lo  <= '0;
      addr    <= '0;
      rem     <= '0;
      bidx    <= '0;
      word    <= '0;
      wpend   <= 1'b0;
    end else begin
      case (st)
        S_HDR: if (acc) begin
          hidx <= hidx + 3'd1;
          case (hidx)
            3'd0: flag_lo <= in_data;
            3'd2: addr[7:0] <= in_data;
            3'd3: addr[15:8] <= in_data;
            3'd4: addr[23:16] <= in_data;
            3'd6: cnt_lo <= in_data;
            3'd7: begin
              rem  <= hdr_cnt;
              word <= '0;
              bidx <= '0;
              if (flag_lo[7:3] != 5'd0)
                st <= S_ERR;
              else if (hdr_cnt == 16'd0)
                st <= is_final ? S_DONE : S_HDR;
              else
                st <= flag_lo[2] ? S_ZERO : S_DATA;
            end
            default: ;
          endcase
        end
        S_DATA: begin
          if (wpend) begin
            if (mem_ready) begin
              wpend <= 1'b0;
              word  <= '0;
              addr  <= addr + 24'd1;
              rem   <= rem - 16'd1;
              if (rem == 16'd1) st <= is_final ? S_DONE : S_HDR;
            end
          end else if (acc) begin
            word[{bidx, 3'b000} +: 8] <= in_data;
            if (last_byte) begin
              wpend <= 1'b1;
              bidx  <= '0;
            end else begin
              bidx <= bidx + 2'd1;
            end
          end
        end
        S_ZERO: if (mem_ready) begin
          addr <= addr + 24'd1;
          rem  <= rem - 16'd1;
          if (rem == 16'd1) st <= is_final ? S_DONE : S_HDR;
        end
        default: ;
      endcase
    end
  end

  p_ready_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> !in_ready);

  p_hold_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_data) && $stable(mem_pm)));

  p_dm_zero_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_pm) |-> (mem_data[23:16] == 8'h00));

  p_zero_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ZERO) |-> (mem_data == 24'h0));

  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wdone && !blk_end) |=> (mem_addr == $past(mem_addr) + 24'd1));

  p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && !in_ready && !mem_wr));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (err && !in_ready && !mem_wr && !done));

endmodule

// File: tb/sim_boot_stream_parser.sv
module sim_boot_stream_parser;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready;
  logic        mem_wr;
  logic [23:0] mem_addr;
  logic [23:0] mem_data;
  logic        mem_pm;
  logic        mem_ready = 1'b1;
  logic        done;
  logic [23:0] start_addr;
  logic        err;

  always #10 clk = ~clk;

  boot_stream_parser u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_pm(mem_pm), .mem_ready(mem_ready),
    .done(done), .start_addr(start_addr), .err(err)
  );

  localparam int NB = 53;
  localparam logic [7:0] STREAM [NB] = '{
    8'h00,8'h00,8'h45,8'h23,8'h01,8'h00,8'h02,8'h00,8'hEF,8'hCD,8'hAB,8'h56,8'h34,8'h12,
    8'h01,8'h5A,8'hFF,8'hFF,8'h00,8'h00,8'h02,8'h00,8'hEF,8'hBE,8'h02,8'h01,
    8'h05,8'h00,8'h00,8'h01,8'h00,8'h00,8'h03,8'h00,
    8'h00,8'h00,8'h77,8'h77,8'h77,8'h00,8'h00,8'h00,
    8'h02,8'h00,8'h00,8'h00,8'hFF,8'h00,8'h01,8'h00,8'h01,8'h00,8'h00};

  localparam int NW = 8;
  localparam logic [48:0] EXPW [NW] = '{
    {1'b1, 24'h012345, 24'hABCDEF},
    {1'b1, 24'h012346, 24'h123456},
    {1'b0, 24'h00FFFF, 24'h00BEEF},
    {1'b0, 24'h010000, 24'h000102},
    {1'b0, 24'h000100, 24'h000000},
    {1'b0, 24'h000101, 24'h000000},
    {1'b0, 24'h000102, 24'h000000},
    {1'b1, 24'hFF0000, 24'h000001}};

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int nw = 0;
  bit ended = 0;
  bit rnd_mode = 0;
  bit rdy_val = 1;
  logic [15:0] lfsr = 16'hACE1;
  logic [48:0] wlog [64];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !ended) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_up();
    end
  end

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ready = rnd_mode ? lfsr[0] : rdy_val;
  end

  always @(negedge clk) begin
    if (rst_n && mem_wr && mem_ready && nw < 64) begin
      wlog[nw] = {mem_pm, mem_addr, mem_data};
      nw++;
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    nw = 0;
  endtask

  task automatic send(input logic [7:0] b);
    bit taken = 0;
    in_valid = 1'b1;
    in_data = b;
    while (!taken) begin
      @(negedge clk);
      taken = in_ready;
      @(posedge clk);
      #1;
    end
    in_valid = 1'b0;
  endtask

  task automatic send_hdr(input logic [7:0] f, input logic [23:0] a, input logic [15:0] c);
    send(f); send(8'h00);
    send(a[7:0]); send(a[15:8]); send(a[23:16]); send(8'h00);
    send(c[7:0]); send(c[15:8]);
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    // R10 reset state
    chk(in_ready == 1'b1, "R10 in_ready", in_ready, 1);
    chk(mem_wr == 1'b0, "R10 mem_wr", mem_wr, 0);
    chk(done == 1'b0, "R10 done", done, 0);
    chk(err == 1'b0, "R10 err", err, 0);

    // Table walk under random write stalls (R1..R7, R9)
    @(posedge clk); #1;
    rnd_mode = 1;
    for (int i = 0; i < NB; i++) send(STREAM[i]);
    repeat (60) @(negedge clk);
    chk(nw == NW, "R7/R9 write count", nw, NW);
    for (int i = 0; i < NW; i++) begin
      if (EXPW[i][48])
        chk(wlog[i] == EXPW[i], "R1/R2/R4 program write", wlog[i], EXPW[i]);
      else if (EXPW[i][23:0] == 24'h0)
        chk(wlog[i] == EXPW[i], "R5 zero-fill write", wlog[i], EXPW[i]);
      else
        chk(wlog[i] == EXPW[i], "R1/R3/R4 data write", wlog[i], EXPW[i]);
    end
    chk(done == 1'b1, "R6 done", done, 1);
    chk(start_addr == 24'h0, "R6 start_addr", start_addr, 0);
    chk(in_ready == 1'b0, "R6 in_ready low", in_ready, 0);
    chk(err == 1'b0, "R6 no err", err, 0);
    rnd_mode = 0;

    // R5 + R9: final zero-fill with memory held busy
    do_reset();
    rdy_val = 0;
    send_hdr(8'h06, 24'h000010, 16'd2);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(mem_wr && mem_addr == 24'h10 && mem_data == 24'h0 && mem_pm,
          "R9 write held", {mem_wr, mem_pm, mem_addr, mem_data}, {2'b11, 24'h10, 24'h0});
      chk(in_ready == 1'b0, "R9 in_ready low", in_ready, 0);
    end
    @(posedge clk); #1 rdy_val = 1;
    repeat (6) @(negedge clk);
    chk(nw == 2, "R5 zero-fill count", nw, 2);
    chk(wlog[1] == {1'b1, 24'h000011, 24'h0}, "R5/R4 second zero word", wlog[1], {1'b1, 24'h000011, 24'h0});
    chk(done == 1'b1, "R6 done after zero-fill", done, 1);

    // R7: final block with count 0
    do_reset();
    send_hdr(8'h03, 24'h123456, 16'd0);
    repeat (3) @(negedge clk);
    chk(nw == 0, "R7 no writes", nw, 0);
    chk(done == 1'b1, "R7 final empty done", done, 1);

    // R8: reserved flag
    do_reset();
    send_hdr(8'h08, 24'h000020, 16'd5);
    repeat (5) @(negedge clk);
    chk(err == 1'b1, "R8 err set", err, 1);
    chk(in_ready == 1'b0, "R8 in_ready low", in_ready, 0);
    chk(nw == 0, "R8 no writes", nw, 0);
    chk(done == 1'b0, "R8 no done", done, 0);

    finish_up();
  end
endmodule